// File: doc/BRIEF.md
# Processor and Peripheral Clock Power Controller

This block derives the processor clock from a single base clock through a free-running power-of-two divider. It also gates the clocks of eight on-chip peripherals and of the external system clock output. Control is through plain level inputs that chip-level software registers drive. A 3-bit code picks the processor ratio, and a new code is taken only when the divider counter wraps. That wrap is a boundary of the slowest ratio, so every divided clock is low at that point and no shortened phase can appear.

An idle request stops the processor clock in its low phase. Any interrupt request whose enable bit is set clears idle, and the processor clock then resumes at the next rising edge of the selected divided clock. Each peripheral clock has its own enable. A global off control stops the processor clock, all peripheral clocks and the system clock output at once. The real-time-clock oscillator input passes straight through to its output and is never stopped. A separate control bit drives the crystal oscillator enable.

Top module: `pcm_top`

## Requirements
- R1: `div_sel` codes 0, 1, 2, 3 and 4 give a `cpu_clk` period of 4, 8, 16, 32 and 64 base cycles. The high phase and the low phase are each half of the period.
- R2: `div_sel` codes 5, 6 and 7 are ignored, and the ratio in use is kept.
- R3: A new ratio is adopted only when the 6-bit divider counter wraps. This happens every 64 base cycles. No `cpu_clk` high or low phase is ever shorter than 2 base cycles.
- R4: A one-cycle `idle_req` pulse raises `idle`. `cpu_clk` finishes any high phase it is in, then stays low for as long as `idle` is high.
- R5: While idle, a cycle where `irq_req & irq_en` is nonzero clears `idle` on the next edge. `cpu_clk` then rises at the next rising edge of the selected divided clock. Requests with a cleared enable bit have no effect.
- R6: `periph_clk[i]` copies the high phases of `clk_base` while `periph_en[i]` is 1, and stays low otherwise. Bit i is sampled while `clk_base` is low, so a high phase is always either passed whole or blocked whole.
- R7: `global_off` stops `cpu_clk`, every `periph_clk` bit and `sysclk_out`. `rtc_clk` keeps following `rtc_osc`.
- R8: `sysclk_dis` = 1 holds `sysclk_out` low. Otherwise `sysclk_out` copies `clk_base` through the same low-phase enable sampling.
- R9: `xtal_en` equals the inverse of `xtal_dis` as it was one base cycle earlier.
- R10: After reset the ratio is /4, `idle` is 0, `xtal_en` is 1 and `cpu_clk` begins low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rtc_osc | input | 1 | Real-time-clock oscillator, never gated |
| div_sel | input | 3 | Processor ratio code (0../4 to 4../64) |
| idle_req | input | 1 | Pulse to enter idle |
| irq_req | input | 16 | Interrupt request lines |
| irq_en | input | 16 | Per-line wake enable |
| periph_en | input | 8 | Per-peripheral clock enable |
| global_off | input | 1 | Stop all gateable clocks |
| sysclk_dis | input | 1 | Stop the external system clock output |
| xtal_dis | input | 1 | Disable the crystal oscillator |
| cpu_clk | output | 1 | Divided processor clock |
| periph_clk | output | 8 | Gated peripheral clocks |
| rtc_clk | output | 1 | Real-time-clock clock |
| sysclk_out | output | 1 | External system clock |
| xtal_en | output | 1 | Crystal oscillator enable |
| idle | output | 1 | Idle mode active |

## Verification
`cpu_clk` is a registered output. A new ratio therefore shows only after the next counter wrap, which is up to 64 cycles away. For that reason the bench waits 130 base cycles after each code change and then measures two full periods from the edges it samples at falling base-clock edges.

The gated clocks follow `clk_base` within the same high phase. The bench changes enables in a low phase and reads the outputs 2 ns into the following high phase, and again in the low phase.

`idle` and `xtal_en` change one edge after their cause, so the bench reads them at the falling edge that follows. The restart after wake is bounded by one /4 period plus two register stages, and the bench checks that bound.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int unsigned NUM_RATIOS = 5;   // /4 ... /64
  localparam int unsigned MIN_SHIFT  = 2;   // smallest ratio is 2**MIN_SHIFT
  localparam int unsigned CNT_W      = NUM_RATIOS + MIN_SHIFT - 1;
  localparam int unsigned SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    RATIO_4  = 3'd0,
    RATIO_8  = 3'd1,
    RATIO_16 = 3'd2,
    RATIO_32 = 3'd3,
    RATIO_64 = 3'd4
  } ratio_e;
endpackage

// File: rtl/pcm_divider.sv
module pcm_divider
  import pcm_pkg::*;
#(
  parameter logic [SEL_W-1:0] RST_SEL = RATIO_4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  output logic             next_bit,
  output logic             wrap,
  output logic [SEL_W-1:0] cur_sel
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SEL_W-1:0] cur_q, cur_n;

  assign wrap  = &cnt_q;
  assign cnt_n = cnt_q + 1'b1;
  // a new code is taken only at the wrap, where every divided clock falls
  assign cur_n = (wrap && (sel_in < SEL_W'(NUM_RATIOS))) ? sel_in : cur_q;
  assign next_bit = cnt_n[int'(cur_n) + MIN_SHIFT - 1];
  assign cur_sel  = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= RST_SEL;
    end else begin
      cnt_q <= cnt_n;
      cur_q <= cur_n;
    end
  end
endmodule

// File: rtl/pcm_cpu_gate.sv
module pcm_cpu_gate #(
  parameter int unsigned N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             next_bit,
  input  logic             idle_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             global_off,
  output logic             cpu_clk,
  output logic             idle
);
  logic idle_q, idle_n, run_q, cpu_q, wake;

  assign wake   = |(irq_req & irq_en);
  assign idle_n = idle_q ? ~wake : idle_req;

  // the run enable may change only while the divided clock is low,
  // so a high phase is never cut short
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      run_q  <= 1'b1;
      cpu_q  <= 1'b0;
    end else begin
      idle_q <= idle_n;
      if (!next_bit) run_q <= ~idle_n & ~global_off;
      cpu_q  <= next_bit & run_q;
    end
  end

  assign cpu_clk = cpu_q;
  assign idle    = idle_q;
endmodule

// File: rtl/pcm_clk_gate.sv
module pcm_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // transparent while clk is low, so the enable is steady during the high phase
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/pcm_top.sv
module pcm_top
  import pcm_pkg::*;
#(
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned N_IRQ    = 16,
  parameter logic [SEL_W-1:0] RST_SEL = RATIO_4
) (
  input  logic                clk_base,
  input  logic                rst_n,
  input  logic                rtc_osc,
  input  logic [SEL_W-1:0]    div_sel,
  input  logic                idle_req,
  input  logic [N_IRQ-1:0]    irq_req,
  input  logic [N_IRQ-1:0]    irq_en,
  input  logic [N_PERIPH-1:0] periph_en,
  input  logic                global_off,
  input  logic                sysclk_dis,
  input  logic                xtal_dis,
  output logic                cpu_clk,
  output logic [N_PERIPH-1:0] periph_clk,
  output logic                rtc_clk,
  output logic                sysclk_out,
  output logic                xtal_en
  ,output logic               idle
);
  logic             next_bit, wrap;
  logic [SEL_W-1:0] cur_sel;
  logic             xtal_en_q;

  pcm_divider #(.RST_SEL(RST_SEL)) u_div (
    .clk(clk_base), .rst_n(rst_n), .sel_in(div_sel),
    .next_bit(next_bit), .wrap(wrap), .cur_sel(cur_sel)
  );

  pcm_cpu_gate #(.N_IRQ(N_IRQ)) u_cpu (
    .clk(clk_base), .rst_n(rst_n), .next_bit(next_bit),
    .idle_req(idle_req), .irq_req(irq_req), .irq_en(irq_en),
    .global_off(global_off), .cpu_clk(cpu_clk), .idle(idle)
  );

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_periph
    pcm_clk_gate u_gate (
      .clk(clk_base), .en(periph_en[i] & ~global_off), .gclk(periph_clk[i])
    );
  end

  pcm_clk_gate u_sys_gate (
    .clk(clk_base), .en(~sysclk_dis & ~global_off), .gclk(sysclk_out)
  );

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) xtal_en_q <= 1'b1;
    else        xtal_en_q <= ~xtal_dis;
  end

  assign xtal_en = xtal_en_q;
  assign rtc_clk = rtc_osc;
endmodule

// File: rtl/pcm_chk.sv
module pcm_chk #(
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned N_IRQ    = 16,
  parameter int unsigned SEL_W    = 3
) (
  input logic                clk_base,
  input logic                rst_n,
  input logic                cpu_clk,
  input logic                idle,
  input logic [N_IRQ-1:0]    irq_req,
  input logic [N_IRQ-1:0]    irq_en,
  input logic [N_PERIPH-1:0] periph_clk,
  input logic                sysclk_out,
  input logic                xtal_dis,
  input logic                xtal_en,
  input logic                wrap,
  input logic [SEL_W-1:0]    cur_sel
);
  logic [7:0] run_q;
  logic       prev_q, seen_q;

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 8'd0;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= cpu_clk;
      if (cpu_clk != prev_q) begin
        run_q  <= 8'd1;
        seen_q <= 1'b1;
      end else if (run_q != 8'hFF) begin
        run_q <= run_q + 8'd1;
      end
    end
  end

  // R3: every cpu_clk phase lasts at least two base cycles
  a_r3_min_phase: assert property (@(posedge clk_base) disable iff (!rst_n)
    (seen_q && cpu_clk != prev_q) |-> run_q >= 8'd2);

  // R3: ratio register moves only at the counter wrap
  a_r3_switch_at_wrap: assert property (@(posedge clk_base) disable iff (!rst_n)
    !wrap |=> $stable(cur_sel));

  // R4: once idle with the clock low, it stays low
  a_r4_idle_holds_low: assert property (@(posedge clk_base) disable iff (!rst_n)
    (idle && !cpu_clk) |=> !cpu_clk);

  // R5: an enabled request ends idle
  a_r5_wake: assert property (@(posedge clk_base) disable iff (!rst_n)
    (idle && |(irq_req & irq_en)) |=> !idle);

  // R6: gated peripheral clocks are low whenever the base clock is low
  a_r6_periph_low_phase: assert property (@(posedge clk_base) disable iff (!rst_n)
    periph_clk == '0);

  // R8: the system clock output is low whenever the base clock is low
  a_r8_sys_low_phase: assert property (@(posedge clk_base) disable iff (!rst_n)
    !sysclk_out);

  // R9: crystal enable follows its control one cycle later
  a_r9_xtal: assert property (@(posedge clk_base) disable iff (!rst_n)
    1'b1 |=> xtal_en == !$past(xtal_dis));
endmodule

bind pcm_top pcm_chk #(.N_PERIPH(N_PERIPH), .N_IRQ(N_IRQ), .SEL_W(pcm_pkg::SEL_W)) u_chk (
  .clk_base(clk_base), .rst_n(rst_n), .cpu_clk(cpu_clk), .idle(idle),
  .irq_req(irq_req), .irq_en(irq_en), .periph_clk(periph_clk),
  .sysclk_out(sysclk_out), .xtal_dis(xtal_dis), .xtal_en(xtal_en),
  .wrap(wrap), .cur_sel(cur_sel)
);

// File: tb/tb_pcm_top.sv
module tb_pcm_top;
  logic        clk_base = 1'b0, rst_n = 1'b0, rtc_osc = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic        idle_req = 1'b0;
  logic [15:0] irq_req = '0, irq_en = '0;
  logic [7:0]  periph_en = '0;
  logic        global_off = 1'b0, sysclk_dis = 1'b0, xtal_dis = 1'b0;
  logic        cpu_clk, rtc_clk, sysclk_out, xtal_en, idle;
  logic [7:0]  periph_clk;

  int checks = 0, errors = 0;
  int cpu_edges = 0, rtc_edges = 0;

  pcm_top dut (
    .clk_base(clk_base), .rst_n(rst_n), .rtc_osc(rtc_osc), .div_sel(div_sel),
    .idle_req(idle_req), .irq_req(irq_req), .irq_en(irq_en),
    .periph_en(periph_en), .global_off(global_off), .sysclk_dis(sysclk_dis),
    .xtal_dis(xtal_dis), .cpu_clk(cpu_clk), .periph_clk(periph_clk),
    .rtc_clk(rtc_clk), .sysclk_out(sysclk_out), .xtal_en(xtal_en), .idle(idle)
  );

  always #4 clk_base = ~clk_base;
  always #40 rtc_osc = ~rtc_osc;
  always @(posedge cpu_clk) cpu_edges++;
  always @(posedge rtc_clk) rtc_edges++;

  typedef struct packed { logic [2:0] code; logic [7:0] per; } vec_t;
  localparam vec_t VEC [8] = '{
    '{3'd0, 8'd4}, '{3'd2, 8'd16}, '{3'd4, 8'd64}, '{3'd1, 8'd8},
    '{3'd3, 8'd32}, '{3'd6, 8'd32}, '{3'd0, 8'd4}, '{3'd7, 8'd4}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_base);
  endtask

  // samples cpu_clk at falling base edges: returns period and high length
  task automatic measure(output int per, output int hi);
    logic p;
    int t;
    per = 0; hi = 0; t = 0;
    p = cpu_clk;
    while (!(p == 1'b0 && cpu_clk == 1'b1) && t < 300) begin
      p = cpu_clk; @(negedge clk_base); t++;
    end
    while (cpu_clk && t < 300) begin hi++; @(negedge clk_base); t++; end
    per = hi;
    while (!cpu_clk && t < 300) begin per++; @(negedge clk_base); t++; end
  endtask

  initial begin
    int per, hi, c0, r0, lat;
    repeat (3) @(negedge clk_base);
    // R10: reset state
    check("R10 idle", idle, 0);
    check("R10 xtal_en", xtal_en, 1);
    check("R10 cpu_clk", cpu_clk, 0);
    rst_n = 1'b1;
    cyc(2);
    measure(per, hi);
    check("R10 reset ratio", per, 4);

    // R1 R2 R3: ratio table
    foreach (VEC[k]) begin
      div_sel = VEC[k].code;
      cyc(130);
      measure(per, hi);
      measure(per, hi);
      check(VEC[k].code > 3'd4 ? "R2 ignored code" : "R1 period", per, int'(VEC[k].per));
      check("R1 R3 high phase", hi, int'(VEC[k].per) / 2);
    end
    div_sel = 3'd0;
    cyc(130);

    // R4: idle stops cpu_clk
    idle_req = 1'b1; cyc(1); idle_req = 1'b0;
    check("R4 idle set", idle, 1);
    cyc(4);
    c0 = cpu_edges;
    irq_req = 16'h0F0F; irq_en = 16'hF0F0;  // R5: masked requests ignored
    cyc(100);
    check("R4 no cpu edges in idle", cpu_edges - c0, 0);
    check("R5 masked irq keeps idle", idle, 1);
    irq_en = 16'h0100;
    cyc(1);
    check("R5 wake", idle, 0);
    lat = 0;
    while (!cpu_clk && lat < 20) begin cyc(1); lat++; end
    check("R5 restart latency within one period", int'(lat <= 5), 1);
    irq_req = '0; irq_en = '0;

    // R6: per-peripheral gating, several patterns
    foreach (VEC[k]) begin
      periph_en = 8'hA5 ^ {VEC[k].code, 5'd0} ^ VEC[k].per;
      @(posedge clk_base); #2;
      check("R6 high phase", periph_clk, periph_en);
      @(negedge clk_base); #1;
      check("R6 low phase", periph_clk, 0);
    end

    // R8: system clock output
    @(negedge clk_base); sysclk_dis = 1'b0;
    @(posedge clk_base); #2;
    check("R8 sysclk runs", sysclk_out, 1);
    @(negedge clk_base); sysclk_dis = 1'b1;
    @(posedge clk_base); #2;
    check("R8 sysclk disabled", sysclk_out, 0);
    @(negedge clk_base); sysclk_dis = 1'b0;

    // R7: global off
    periph_en = 8'hFF;
    global_off = 1'b1;
    cyc(8);
    c0 = cpu_edges; r0 = rtc_edges;
    @(posedge clk_base); #2;
    check("R7 periph off", periph_clk, 0);
    check("R7 sysclk off", sysclk_out, 0);
    cyc(60);
    check("R7 cpu stopped", cpu_edges - c0, 0);
    check("R7 rtc runs", int'(rtc_edges - r0 >= 5), 1);
    global_off = 1'b0;
    @(posedge clk_base); #2;
    check("R7 periph back", periph_clk, 8'hFF);
    cyc(20);
    check("R7 cpu back", int'(cpu_edges - c0 > 0), 1);

    // R9: crystal enable
    @(negedge clk_base); xtal_dis = 1'b1;
    check("R9 not yet", xtal_en, 1);
    @(negedge clk_base);
    check("R9 disabled", xtal_en, 0);
    xtal_dis = 1'b0;
    @(negedge clk_base);
    check("R9 enabled", xtal_en, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule